// File: doc/BRIEF.md
# Three-Port Parallel I/O Register Block

This block gives a processor three 8-bit parallel ports, A, B and C, on a small strobed register bus. The bus uses an active-low chip select, separate active-low read and write strobes, a 2-bit register select and 8-bit data in and out. Each port has an output latch. Its direction is set by a mode word, per port for A and B and per 4-bit half for C. A pin set as output drives its latch value. A pin set as input is read straight from the pad with no latching.

Register select 3 is the control address, and a write there means one of two things. With data bit 7 set, the byte is a new mode word. It sets all directions and clears every output latch. With bit 7 clear, the byte is a single-bit command on the port C latch. Bits 3..1 pick the bit and bit 0 gives its new value. A read of the control address returns the last mode word.

Pads are modelled as separate input, output and output-enable vectors per port. Writes take effect on the clock edge that samples an active write. Read data is combinational while a read is active.

Top module: `pio3_port`

## Requirements
- R1: After reset every output enable is 0, every output latch is 0, and a control read returns 9Bh.
- R2: An access happens only while `cs_n` is 0 and exactly one of `rd_n`/`wr_n` is 0. In any other cycle no latch or mode word changes, and `dout_oe` is 0 with `dout` 0.
- R3: A write with `addr` 0, 1 or 2 loads `din` into the A, B or C output latch. The value is visible on `pa_out`, `pb_out` or `pc_out` in the next cycle.
- R4: Mode-word bits set the direction, with 1 meaning input. Bit 4 controls port A, bit 1 controls port B, bit 3 controls C[7:4] and bit 0 controls C[3:0]. Each output enable is the inverse of its bit across the whole group.
- R5: A mode-word write (control address, `din[7]`=1) clears all three output latches to 0.
- R6: A control write with `din[7]`=0 sets C latch bit `din[3:1]` to `din[0]`. Every other C bit and the stored mode word stay as they were.
- R7: A read of port A, B or C returns the latch for bits that are outputs and the live input pin for bits that are inputs, in the same cycle.
- R8: A control read returns the most recently written mode word.
- R9: Mode word 8Bh makes A an output and B and all of C inputs. Mode word 89h makes A and B outputs and all of C an input.
- R10: The two halves of port C are independent. With mode word 81h, C[7:4] drives its latch while C[3:0] reads its pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Register select: 0 A, 1 B, 2 C, 3 control |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, 0 when no read |
| dout_oe | output | 1 | High while a read is active |
| pa_in | input | 8 | Port A pin inputs |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B pin inputs |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B output enables |
| pc_in | input | 8 | Port C pin inputs |
| pc_out | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C output enables |

## Verification
The properties assume the bus inputs are stable around each rising clock edge and that reset is held long enough for the first sampled cycle to show idle strobes. The bench meets both conditions. It changes every bus and pin input only on the falling edge and keeps all strobes high throughout reset. It also drives deliberately illegal strobe combinations, such as both strobes low or strobes active with chip select high. These show that such cycles leave the registers untouched.

// File: rtl/pio3_port.sv
module pio3_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_n,
  input  logic         rd_n,
  input  logic         wr_n,
  input  logic [1:0]   addr,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         dout_oe,
  input  logic [W-1:0] pa_in,
  output logic [W-1:0] pa_out,
  output logic [W-1:0] pa_oe,
  input  logic [W-1:0] pb_in,
  output logic [W-1:0] pb_out,
  output logic [W-1:0] pb_oe,
  input  logic [W-1:0] pc_in,
  output logic [W-1:0] pc_out,
  output logic [W-1:0] pc_oe
);
  localparam int H = W / 2;
  localparam logic [7:0] MODE_RST = 8'h9B;

  logic [7:0]   mode_q;
  logic [W-1:0] la_q, lb_q, lc_q;
  logic         rd_act, wr_act;

  assign rd_act = !cs_n && !rd_n && wr_n;
  assign wr_act = !cs_n && !wr_n && rd_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_RST;
      la_q   <= '0;
      lb_q   <= '0;
      lc_q   <= '0;
    end else if (wr_act) begin
      case (addr)
        2'd0: la_q <= din;
        2'd1: lb_q <= din;
        2'd2: lc_q <= din;
        default: begin
          if (din[7]) begin
            mode_q <= din[7:0];
            la_q   <= '0;
            lb_q   <= '0;
            lc_q   <= '0;
          end else begin
            lc_q[din[3:1]] <= din[0];
          end
        end
      endcase
    end
  end

  assign pa_oe  = {W{~mode_q[4]}};
  assign pb_oe  = {W{~mode_q[1]}};
  assign pc_oe  = {{H{~mode_q[3]}}, {H{~mode_q[0]}}};
  assign pa_out = la_q;
  assign pb_out = lb_q;
  assign pc_out = lc_q;

  logic [W-1:0] rd_mux;
  always_comb begin
    case (addr)
      2'd0:    rd_mux = (la_q & pa_oe) | (pa_in & ~pa_oe);
      2'd1:    rd_mux = (lb_q & pb_oe) | (pb_in & ~pb_oe);
      2'd2:    rd_mux = (lc_q & pc_oe) | (pc_in & ~pc_oe);
      default: rd_mux = W'(mode_q);
    endcase
  end

  assign dout_oe = rd_act;
  assign dout    = rd_act ? rd_mux : '0;
endmodule

// File: rtl/pio3_port_chk.sv
module pio3_port_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cs_n,
  input logic         rd_n,
  input logic         wr_n,
  input logic [1:0]   addr,
  input logic [W-1:0] din,
  input logic [W-1:0] dout,
  input logic         dout_oe,
  input logic [W-1:0] pa_in,
  input logic [W-1:0] pa_out,
  input logic [W-1:0] pa_oe,
  input logic [W-1:0] pb_in,
  input logic [W-1:0] pb_out,
  input logic [W-1:0] pb_oe,
  input logic [W-1:0] pc_in,
  input logic [W-1:0] pc_out,
  input logic [W-1:0] pc_oe
);
  logic wr_ok, idle;
  assign wr_ok = !cs_n && !wr_n && rd_n;
  assign idle  = cs_n || (rd_n == wr_n);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle |=> $stable(pa_out) && $stable(pb_out) && $stable(pc_out) && $stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe));

  // R3
  port_a_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok && addr == 2'd0 |=> pa_out == $past(din));

  // R4
  group_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pa_oe == '0 || pa_oe == '1) && (pb_oe == '0 || pb_oe == '1));

  // R5
  mode_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok && addr == 2'd3 && din[7] |=> pa_out == '0 && pb_out == '0 && pc_out == '0);

  // R6
  bit_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok && addr == 2'd3 && !din[7] |=>
      pc_out[$past(din[3:1])] == $past(din[0]) &&
      (($past(pc_out) ^ pc_out) & ~(W'(1) << $past(din[3:1]))) == '0 &&
      $stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe));

  // R7
  read_mux_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dout_oe && addr != 2'd3 |->
      dout == ((addr == 2'd0) ? ((pa_out & pa_oe) | (pa_in & ~pa_oe)) :
               (addr == 2'd1) ? ((pb_out & pb_oe) | (pb_in & ~pb_oe)) :
                                ((pc_out & pc_oe) | (pc_in & ~pc_oe))));
endmodule

bind pio3_port pio3_port_chk #(.W(W)) u_chk (.*);

// File: tb/sim_pio3_port.sv
`timescale 1ns/1ps
module sim_pio3_port;
  logic       clk = 0, rst_n = 0;
  logic       cs_n = 1, rd_n = 1, wr_n = 1;
  logic [1:0] addr = 0;
  logic [7:0] din = 0;
  logic [7:0] dout;
  logic       dout_oe;
  logic [7:0] pa_in = 0, pb_in = 0, pc_in = 0;
  logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pio3_port u0 (.*);

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); cs_n = 0; wr_n = 0; addr = a; din = d;
    @(negedge clk); cs_n = 1; wr_n = 1;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); cs_n = 0; rd_n = 0; addr = a;
    #1 d = dout;
    @(negedge clk); cs_n = 1; rd_n = 1;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check(pa_oe == 0 && pb_oe == 0 && pc_oe == 0, "R1 oe", pa_oe | pb_oe | pc_oe, 8'h00);
    check(pa_out == 0 && pb_out == 0 && pc_out == 0, "R1 latch", pa_out | pb_out | pc_out, 8'h00);
    rd(2'd3, v); check(v == 8'h9B, "R1 ctrl", v, 8'h9B);
    pa_in = 8'h5A; rd(2'd0, v); check(v == 8'h5A, "R7 input pin A", v, 8'h5A);
  endtask

  task automatic t_mode8b();
    logic [7:0] v;
    wr(2'd3, 8'h8B);
    check(pa_oe == 8'hFF && pb_oe == 0 && pc_oe == 0, "R9 8Bh dir", {pa_oe[0], pb_oe[0], pc_oe[7], pc_oe[0]}, 8'h08);
    check(pa_oe == 8'hFF, "R4 A bit4", pa_oe, 8'hFF);
    rd(2'd3, v); check(v == 8'h8B, "R8 ctrl", v, 8'h8B);
    wr(2'd0, 8'h3C);
    check(pa_out == 8'h3C, "R3 A latch", pa_out, 8'h3C);
    pa_in = 8'hFF; rd(2'd0, v); check(v == 8'h3C, "R7 output A", v, 8'h3C);
    pb_in = 8'hC3; rd(2'd1, v); check(v == 8'hC3, "R7 input B", v, 8'hC3);
  endtask

  task automatic t_mode89();
    logic [7:0] v;
    wr(2'd3, 8'h89);
    check(pa_oe == 8'hFF && pb_oe == 8'hFF && pc_oe == 0, "R9 89h dir", pc_oe, 8'h00);
    check(pa_out == 0, "R5 clear A", pa_out, 8'h00);
    wr(2'd1, 8'h77);
    check(pb_out == 8'h77, "R3 B latch", pb_out, 8'h77);
    wr(2'd0, 8'h12);
    wr(2'd3, 8'h89);
    check(pa_out == 0 && pb_out == 0, "R5 clear AB", pa_out | pb_out, 8'h00);
  endtask

  task automatic t_halves();
    logic [7:0] v;
    wr(2'd3, 8'h81);
    check(pc_oe == 8'hF0, "R10 C halves oe", pc_oe, 8'hF0);
    check(pb_oe == 8'hFF, "R4 B bit1", pb_oe, 8'hFF);
    wr(2'd2, 8'hA5);
    check(pc_out == 8'hA5, "R3 C latch", pc_out, 8'hA5);
    pc_in = 8'h3C; rd(2'd2, v); check(v == 8'hAC, "R10 C mixed read", v, 8'hAC);
    wr(2'd3, 8'h88);
    check(pc_oe == 8'h0F, "R4 C upper bit3", pc_oe, 8'h0F);
  endtask

  task automatic t_bitcmd();
    logic [7:0] v;
    wr(2'd3, 8'h80);
    wr(2'd3, 8'h05); check(pc_out == 8'h04, "R6 set bit2", pc_out, 8'h04);
    wr(2'd3, 8'h0F); check(pc_out == 8'h84, "R6 set bit7", pc_out, 8'h84);
    wr(2'd3, 8'h04); check(pc_out == 8'h80, "R6 clear bit2", pc_out, 8'h80);
    rd(2'd3, v); check(v == 8'h80, "R6 mode kept", v, 8'h80);
    check(pc_oe == 8'hFF, "R6 dir kept", pc_oe, 8'hFF);
  endtask

  task automatic t_ignore();
    logic [7:0] v;
    wr(2'd0, 8'h11);
    @(negedge clk); cs_n = 1; wr_n = 0; addr = 0; din = 8'hFF;
    @(negedge clk); wr_n = 1;
    check(pa_out == 8'h11, "R2 cs high write", pa_out, 8'h11);
    @(negedge clk); cs_n = 0; wr_n = 0; rd_n = 0; addr = 2'd3; din = 8'h9B;
    #1 check(dout_oe == 0 && dout == 0, "R2 both strobes no read", dout, 8'h00);
    @(negedge clk); cs_n = 1; wr_n = 1; rd_n = 1;
    check(pa_out == 8'h11 && pa_oe == 8'hFF, "R2 both strobes no write", pa_out, 8'h11);
    @(negedge clk); rd_n = 0;
    #1 check(dout_oe == 0, "R2 cs high read", {7'd0, dout_oe}, 8'h00);
    @(negedge clk); rd_n = 1;
    rd(2'd3, v); check(v == 8'h80, "R8 ctrl unchanged", v, 8'h80);
  endtask

  initial begin
    #10000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=00 expected=01");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_mode8b();
    t_mode89();
    t_halves();
    t_bitcmd();
    t_ignore();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule